// File: doc/BRIEF.md
# Single-Word SDR SDRAM Controller

This block drives an SDR SDRAM device from a slow system clock (around 27 MHz). After reset it holds the memory idle for the power-up time. It then brings the device up with one precharge-all, a train of auto-refresh commands and a mode-register load. From then on it serves one access at a time from a simple user port. Each access is a single word, read or written, at one fixed row, column and bank. The clock is slow enough that every timing gap between commands costs only one or two cycles.

There is no refresh timer. The controller counts completed accesses and inserts one auto-refresh after every 64th one, before it accepts the next request. At the slow clock the longest access takes under 200 ns. At that length, 64 accesses stay well inside the budget of one refresh every 15.6 µs. Chip select and clock enable are tied active, so every command is carried on the three strobe pins alone. The byte masks are driven low whenever data moves.

Top module: `sdram_single_ctrl`

## Requirements
- R1: After the last clock edge at which `rst` is high, the controller issues NOP (ras_n, cas_n, we_n = 1,1,1) with `sd_dqm` all ones for exactly POWERUP_CYCLES cycles (default 5400, 200 µs at 27 MHz).
- R2: The first command after the power-up wait is precharge-all (0,1,0) with address bit 10 set and all other address bits zero. GAP_RP cycles later the first of eight auto-refreshes (0,0,1) follows. The refreshes are spaced GAP_RFC cycles apart.
- R3: GAP_RFC cycles after the eighth refresh the controller issues mode-register-set (0,0,0) with address 12'h220 (burst length 1, sequential, CAS latency 2, single-word writes) and bank 0. The first idle cycle follows GAP_MRD cycles later.
- R4: A request seen with `wr_sel`=1 in an idle cycle gives ACTIVE (0,1,1) with the fixed row and bank in the next cycle. WRITE (1,0,0) follows GAP_RCD cycles later with address = column | bit 10 (auto-precharge) and `sd_dq` = the `wdata` sampled at the request. The next idle cycle follows GAP_WRP cycles after WRITE. Later changes to `wdata` and `wr_sel` have no effect on that access.
- R5: A request with `wr_sel`=0 gives ACTIVE, then READ (1,0,1) GAP_RCD cycles later with the same address as a write. The word on `sd_dq` at the clock edge CAS_LATENCY cycles after the READ command is sampled appears on `rdata`. It is flagged by `rvalid` high for exactly one cycle, CAS_LATENCY+1 cycles after the READ cycle. The next cycle is idle.
- R6: `sd_dqm` is all ones from reset until the first idle cycle and all zeros in every cycle after that, including every read and write.
- R7: After every 64th completed access, the cycle that would have been idle instead carries auto-refresh with address and bank zero. Idle resumes GAP_RFC cycles later. A request held high across that interval starts no access until idle resumes.
- R8: The controller drives `sd_dq` only in the WRITE command cycle. In every other cycle the bus is free for the memory to drive.
- R9: Every cycle that carries no command is a NOP (1,1,1), including idle and all gap cycles.
- R10: A high `rst` at a clock edge returns the controller from any state to the power-up wait. A new full initialization then follows.
- R11: `sd_cke` is always 1 and `sd_cs_n` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, sampled in idle cycles |
| wr_sel | input | 1 | 1 = write, 0 = read, sampled with `req` |
| wdata | input | 16 | Write word, sampled with `req` |
| rdata | output | 16 | Last word read from memory |
| rvalid | output | 1 | One-cycle strobe marking a fresh `rdata` |
| sd_cke | output | 1 | Memory clock enable, tied high |
| sd_cs_n | output | 1 | Memory chip select, tied low |
| sd_ras_n | output | 1 | Row strobe command pin |
| sd_cas_n | output | 1 | Column strobe command pin |
| sd_we_n | output | 1 | Write-enable command pin |
| sd_addr | output | 12 | Memory address bus |
| sd_ba | output | 2 | Memory bank select |
| sd_dqm | output | 2 | Active-high byte masks |
| sd_dq | inout | 16 | Bidirectional memory data bus |

## Verification
The hardest case to reach is the access-count refresh: it appears only after 64 complete accesses. It matters most when a request is already pending as the count wraps. The stimulus runs more than two full intervals of mixed reads and writes, several of them back to back with `req` held high. The 64th access of each interval is one of those held accesses, so the refresh must win over a live request. A reset landing in the middle of a write, right after ACTIVE, then forces a second complete power-up and initialization. After that, reads must return the word written before the reset.

// File: rtl/sdram_single_pkg.sv
package sdram_single_pkg;

    typedef enum logic [3:0] {
        ST_PWR, ST_PRE, ST_REF_INIT, ST_MRS, ST_IDLE, ST_ACT,
        ST_WR, ST_RD, ST_CAP, ST_DONE, ST_AREF, ST_WAIT
    } state_e;

    // Encoded on {ras_n, cas_n, we_n}
    typedef enum logic [2:0] {
        CMD_MRS  = 3'b000,
        CMD_REF  = 3'b001,
        CMD_PRE  = 3'b010,
        CMD_ACT  = 3'b011,
        CMD_WR   = 3'b100,
        CMD_RD   = 3'b101,
        CMD_NOP  = 3'b111
    } cmd_e;

    function automatic cmd_e state_cmd(state_e s);
        case (s)
            ST_PRE:               return CMD_PRE;
            ST_REF_INIT, ST_AREF: return CMD_REF;
            ST_MRS:               return CMD_MRS;
            ST_ACT:               return CMD_ACT;
            ST_WR:                return CMD_WR;
            ST_RD:                return CMD_RD;
            default:              return CMD_NOP;
        endcase
    endfunction

    // Mode word: burst length 1, sequential, given CAS latency, single-word write
    function automatic logic [11:0] mode_word(int unsigned cas_lat);
        logic [11:0] m;
        m = 12'h000;
        m[6:4] = 3'(cas_lat);
        m[9] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
    import sdram_single_pkg::*;
#(
    parameter int unsigned POWERUP_CYCLES     = 5400,
    parameter int unsigned INIT_REFRESHES     = 8,
    parameter int unsigned ACCESS_PER_REFRESH = 64,
    parameter int unsigned GAP_RP             = 1,
    parameter int unsigned GAP_RFC            = 2,
    parameter int unsigned GAP_MRD            = 2,
    parameter int unsigned GAP_RCD            = 1,
    parameter int unsigned GAP_WRP            = 2,
    parameter int unsigned CAS_LATENCY        = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req,
    input  logic   wr_sel,
    output state_e state,
    output logic   init_active,
    output logic   accept
);

    localparam int unsigned CW    = $clog2(POWERUP_CYCLES + GAP_RFC + GAP_MRD + GAP_WRP + CAS_LATENCY + 1);
    localparam int unsigned IRW   = $clog2(INIT_REFRESHES + 1);
    localparam int unsigned ACC_W = $clog2(ACCESS_PER_REFRESH + 1);

    typedef struct packed {
        state_e          st;
        state_e          after;
        logic [CW-1:0]   cnt;
    } step_t;

    // Move to tgt so that it starts gap cycles after the current command cycle
    function automatic step_t plan(int unsigned gap, state_e tgt);
        step_t s;
        if (gap > 1) begin
            s.st    = ST_WAIT;
            s.after = tgt;
            s.cnt   = CW'(gap - 2);
        end else begin
            s.st    = tgt;
            s.after = tgt;
            s.cnt   = '0;
        end
        return s;
    endfunction

    step_t            cur_q, nxt;
    logic [IRW-1:0]   iref_q, iref_d;
    logic [ACC_W-1:0] acc_q, acc_d;
    logic             wr_q, wr_d;
    logic             init_q;
    logic             last_acc;

    assign last_acc = (acc_q == ACC_W'(ACCESS_PER_REFRESH - 1));

    always_comb begin
        nxt    = cur_q;
        iref_d = iref_q;
        acc_d  = acc_q;
        wr_d   = wr_q;
        accept = 1'b0;
        case (cur_q.st)
            ST_PWR: begin
                if (cur_q.cnt == '0) nxt.st = ST_PRE;
                else                 nxt.cnt = cur_q.cnt - 1'b1;
            end
            ST_PRE: begin
                iref_d = '0;
                nxt    = plan(GAP_RP, ST_REF_INIT);
            end
            ST_REF_INIT: begin
                if (iref_q == IRW'(INIT_REFRESHES - 1)) begin
                    nxt = plan(GAP_RFC, ST_MRS);
                end else begin
                    iref_d = iref_q + 1'b1;
                    nxt    = plan(GAP_RFC, ST_REF_INIT);
                end
            end
            ST_MRS:  nxt = plan(GAP_MRD, ST_IDLE);
            ST_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    wr_d   = wr_sel;
                    nxt.st = ST_ACT;
                end
            end
            ST_ACT:  nxt = plan(GAP_RCD, wr_q ? ST_WR : ST_RD);
            ST_RD:   nxt = plan(CAS_LATENCY, ST_CAP);
            ST_CAP:  nxt.st = ST_DONE;
            ST_WR, ST_DONE: begin
                acc_d = last_acc ? '0 : acc_q + 1'b1;
                nxt   = plan((cur_q.st == ST_WR) ? GAP_WRP : 1,
                             last_acc ? ST_AREF : ST_IDLE);
            end
            ST_AREF: nxt = plan(GAP_RFC, ST_IDLE);
            ST_WAIT: begin
                if (cur_q.cnt == '0) nxt.st = cur_q.after;
                else                 nxt.cnt = cur_q.cnt - 1'b1;
            end
            default: nxt.st = ST_PWR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.st    <= ST_PWR;
            cur_q.after <= ST_IDLE;
            cur_q.cnt   <= CW'(POWERUP_CYCLES - 1);
            iref_q      <= '0;
            acc_q       <= '0;
            wr_q        <= 1'b0;
            init_q      <= 1'b1;
        end else begin
            cur_q  <= nxt;
            iref_q <= iref_d;
            acc_q  <= acc_d;
            wr_q   <= wr_d;
            init_q <= init_q && (nxt.st != ST_IDLE);
        end
    end

    assign state       = cur_q.st;
    assign init_active = init_q;

endmodule

// File: rtl/sdram_pin_drv.sv
module sdram_pin_drv
    import sdram_single_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned BA_W        = 2,
    parameter int unsigned COL_W       = 8,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned DQM_W       = 2,
    parameter int unsigned AP_BIT      = 10,
    parameter int unsigned CAS_LATENCY = 2,
    parameter logic [ADDR_W-1:0] FIX_ROW  = 12'h05A,
    parameter logic [COL_W-1:0]  FIX_COL  = 8'h3C,
    parameter logic [BA_W-1:0]   FIX_BANK = 2'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  state_e            state,
    input  logic              init_active,
    input  logic              accept,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic [DQM_W-1:0]  dqm,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    localparam logic [ADDR_W-1:0] AP_MASK  = ADDR_W'(1) << AP_BIT;
    localparam logic [ADDR_W-1:0] MODE_VAL = ADDR_W'(mode_word(CAS_LATENCY));

    logic [DATA_W-1:0] wdata_q, rdata_q;

    always_comb begin
        {ras_n, cas_n, we_n} = state_cmd(state);
        addr = '0;
        ba   = '0;
        case (state)
            ST_PRE: addr = AP_MASK;
            ST_ACT: begin
                addr = FIX_ROW;
                ba   = FIX_BANK;
            end
            ST_RD, ST_WR: begin
                addr = AP_MASK | ADDR_W'(FIX_COL);
                ba   = FIX_BANK;
            end
            ST_MRS: addr = MODE_VAL;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept)          wdata_q <= wdata;
            if (state == ST_CAP) rdata_q <= dq_in;
        end
    end

    assign dqm    = {DQM_W{init_active}};
    assign dq_out = wdata_q;
    assign dq_oe  = (state == ST_WR);
    assign rdata  = rdata_q;
    assign rvalid = (state == ST_DONE);

endmodule

// File: rtl/sdram_single_ctrl.sv
module sdram_single_ctrl
    import sdram_single_pkg::*;
#(
    parameter int unsigned POWERUP_CYCLES     = 5400,
    parameter int unsigned INIT_REFRESHES     = 8,
    parameter int unsigned ACCESS_PER_REFRESH = 64,
    parameter int unsigned GAP_RP             = 1,
    parameter int unsigned GAP_RFC            = 2,
    parameter int unsigned GAP_MRD            = 2,
    parameter int unsigned GAP_RCD            = 1,
    parameter int unsigned GAP_WRP            = 2,
    parameter int unsigned CAS_LATENCY        = 2,
    parameter int unsigned ADDR_W             = 12,
    parameter int unsigned BA_W               = 2,
    parameter int unsigned COL_W              = 8,
    parameter int unsigned DATA_W             = 16,
    parameter int unsigned DQM_W              = 2,
    parameter logic [ADDR_W-1:0] FIX_ROW      = 12'h05A,
    parameter logic [COL_W-1:0]  FIX_COL      = 8'h3C,
    parameter logic [BA_W-1:0]   FIX_BANK     = 2'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba,
    output logic [DQM_W-1:0]  sd_dqm,
    inout  wire  [DATA_W-1:0] sd_dq
);

    state_e            state;
    logic              init_active, accept, dq_oe;
    logic [DATA_W-1:0] dq_out;

    sdram_seq_fsm #(
        .POWERUP_CYCLES(POWERUP_CYCLES), .INIT_REFRESHES(INIT_REFRESHES),
        .ACCESS_PER_REFRESH(ACCESS_PER_REFRESH), .GAP_RP(GAP_RP),
        .GAP_RFC(GAP_RFC), .GAP_MRD(GAP_MRD), .GAP_RCD(GAP_RCD),
        .GAP_WRP(GAP_WRP), .CAS_LATENCY(CAS_LATENCY)
    ) fsm_i (
        .clk(clk), .rst(rst), .req(req), .wr_sel(wr_sel),
        .state(state), .init_active(init_active), .accept(accept)
    );

    sdram_pin_drv #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .DQM_W(DQM_W), .AP_BIT(10), .CAS_LATENCY(CAS_LATENCY),
        .FIX_ROW(FIX_ROW), .FIX_COL(FIX_COL), .FIX_BANK(FIX_BANK)
    ) pins_i (
        .clk(clk), .rst(rst), .state(state), .init_active(init_active),
        .accept(accept), .wdata(wdata), .dq_in(sd_dq),
        .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
        .addr(sd_addr), .ba(sd_ba), .dqm(sd_dqm),
        .dq_out(dq_out), .dq_oe(dq_oe), .rdata(rdata), .rvalid(rvalid)
    );

    assign sd_cke  = 1'b1;
    assign sd_cs_n = 1'b0;
    assign sd_dq   = dq_oe ? dq_out : {DATA_W{1'bz}};

endmodule

// File: rtl/sdram_single_ctrl_chk.sv
module sdram_single_ctrl_chk #(
    parameter int unsigned POWERUP_CYCLES     = 5400,
    parameter int unsigned ACCESS_PER_REFRESH = 64,
    parameter int unsigned ADDR_W             = 12,
    parameter int unsigned DQM_W              = 2,
    parameter int unsigned CAS_LATENCY        = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              sd_cke,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic [DQM_W-1:0]  sd_dqm,
    input logic              dq_oe,
    input logic              rvalid
);
    import sdram_single_pkg::*;

    localparam int unsigned PW = $clog2(POWERUP_CYCLES + 1);
    localparam int unsigned AW = $clog2(ACCESS_PER_REFRESH + 2);

    logic [2:0]    cmd;
    logic [PW-1:0] since_rst;
    logic [AW-1:0] acc_since_ref;
    logic          is_rw;

    assign cmd   = {sd_ras_n, sd_cas_n, sd_we_n};
    assign is_rw = (cmd == CMD_RD) || (cmd == CMD_WR);

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst     <= '0;
            acc_since_ref <= '0;
        end else begin
            if (since_rst != PW'(POWERUP_CYCLES)) since_rst <= since_rst + 1'b1;
            if (cmd == CMD_REF)  acc_since_ref <= '0;
            else if (is_rw)      acc_since_ref <= acc_since_ref + 1'b1;
        end
    end

    // R1
    powerup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_NOP) |-> (since_rst == PW'(POWERUP_CYCLES)));

    // R2
    precharge_all_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE) |-> sd_addr[10]);

    // R3
    mode_word_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_MRS) |-> (sd_addr == ADDR_W'(mode_word(CAS_LATENCY))));

    // R4
    autoprecharge_chk: assert property (@(posedge clk) disable iff (rst)
        is_rw |-> sd_addr[10]);

    // R5
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);

    // R6
    mask_open_chk: assert property (@(posedge clk) disable iff (rst)
        is_rw |-> (sd_dqm == '0));

    // R7
    refresh_due_chk: assert property (@(posedge clk) disable iff (rst)
        is_rw |-> (acc_since_ref < AW'(ACCESS_PER_REFRESH)));

    // R8
    bus_drive_chk: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (cmd == CMD_WR));

    // R8
    write_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_WR) |-> dq_oe);

    // R10
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cmd == CMD_NOP && sd_dqm == '1));

    // R11
    always_comb begin
        pins_tied_chk: assert (rst || (sd_cke && !sd_cs_n));
    end

endmodule

bind sdram_single_ctrl sdram_single_ctrl_chk #(
    .POWERUP_CYCLES(POWERUP_CYCLES), .ACCESS_PER_REFRESH(ACCESS_PER_REFRESH),
    .ADDR_W(ADDR_W), .DQM_W(DQM_W), .CAS_LATENCY(CAS_LATENCY)
) chk_i (
    .clk(clk), .rst(rst), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .sd_dqm(sd_dqm), .dq_oe(dq_oe), .rvalid(rvalid)
);

// File: tb/sdram_single_ctrl_tb.sv
module sdram_single_ctrl_tb_top;

    localparam time CLK_PERIOD = 37ns;
    localparam int  PWR  = 5400;
    localparam int  RP   = 1;
    localparam int  RFC  = 2;
    localparam int  MRD  = 2;
    localparam int  RCD  = 1;
    localparam int  WRP  = 2;
    localparam int  CL   = 2;
    localparam int  NACC = 64;
    localparam logic [11:0] ROW  = 12'h05A;
    localparam logic [11:0] CADR = 12'h43C;
    localparam logic [1:0]  BANK = 2'd1;

    localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101,
                           C_WR = 3'b100, C_PRE = 3'b010, C_REF = 3'b001,
                           C_MRS = 3'b000;

    typedef struct {
        logic [2:0]  cmd;
        logic [11:0] addr;
        logic [1:0]  ba;
        logic [1:0]  dqm;
        bit          dq_chk;
        logic [15:0] dq;
        logic        rv;
        logic [15:0] rd;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        rvalid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [11:0] sd_addr;
    logic [1:0]  sd_ba, sd_dqm;
    wire  [15:0] sd_dq;

    int   n_chk = 0;
    int   n_err = 0;
    int   cyc = 0;
    int   acc_cnt = 0;
    logic [15:0] last_wr = 16'hC3A5;
    exp_t q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdram_single_ctrl dut_i (
        .clk(clk), .rst(rst), .req(req), .wr_sel(wr_sel), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_dqm(sd_dqm), .sd_dq(sd_dq)
    );

    // Behavioural one-word memory with CAS latency 2
    logic [15:0] mem_word = 16'hC3A5;
    logic [15:0] mem_q = 16'h0;
    logic        mem_oe = 1'b0;
    logic        rd_arm = 1'b0;
    assign sd_dq = mem_oe ? mem_q : 16'hzzzz;

    always @(posedge clk) begin
        mem_oe <= rd_arm;
        if (rd_arm) mem_q <= mem_word;
        rd_arm <= ({sd_ras_n, sd_cas_n, sd_we_n} == C_RD);
        if ({sd_ras_n, sd_cas_n, sd_we_n} == C_WR) mem_word <= sd_dq;
    end

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: cycles %0d expected below %0d", cyc, 60000);
            summary();
        end
    end

    task automatic push(logic [2:0] c, logic [11:0] a, logic [1:0] b, logic [1:0] m,
                        bit dc, logic [15:0] d, logic v, logic [15:0] r, string t);
        exp_t e;
        e.cmd = c; e.addr = a; e.ba = b; e.dqm = m; e.dq_chk = dc;
        e.dq = d; e.rv = v; e.rd = r; e.tag = t;
        q.push_back(e);
    endtask

    task automatic nops(int n, logic [1:0] m, string t);
        for (int i = 0; i < n; i++) push(C_NOP, 12'h0, 2'd0, m, 1'b0, 16'h0, 1'b0, 16'h0, t);
    endtask

    task automatic check_now(exp_t e);
        logic [2:0] got;
        got = {sd_ras_n, sd_cas_n, sd_we_n};
        n_chk++;
        if (got !== e.cmd || sd_addr !== e.addr || sd_ba !== e.ba || sd_dqm !== e.dqm ||
            rvalid !== e.rv || (e.rv && rdata !== e.rd)) begin
            n_err++;
            $display("FAIL %s cyc %0d: cmd/addr/ba/dqm/rv/rd got %b/%h/%h/%b/%b/%h exp %b/%h/%h/%b/%b/%h",
                     e.tag, cyc, got, sd_addr, sd_ba, sd_dqm, rvalid, rdata,
                     e.cmd, e.addr, e.ba, e.dqm, e.rv, e.rd);
        end
        if (e.dq_chk) begin
            n_chk++;
            if (sd_dq !== e.dq) begin
                n_err++;
                $display("FAIL R8 (%s) cyc %0d: dq got %h exp %h", e.tag, cyc, sd_dq, e.dq);
            end
        end
        n_chk++;
        if (sd_cke !== 1'b1 || sd_cs_n !== 1'b0) begin
            n_err++;
            $display("FAIL R11 cyc %0d: cke/cs_n got %b/%b exp 1/0", cyc, sd_cke, sd_cs_n);
        end
    endtask

    task automatic drain();
        while (q.size() > 0) begin
            @(negedge clk);
            check_now(q.pop_front());
        end
    endtask

    // Reset, then full power-up and initialization; ends standing in an idle cycle
    task automatic do_reset();
        exp_t e;
        q.delete();
        req = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        e.cmd = C_NOP; e.addr = 12'h0; e.ba = 2'd0; e.dqm = 2'b11; e.dq_chk = 1'b0;
        e.dq = 16'h0; e.rv = 1'b0; e.rd = 16'h0; e.tag = "R10";
        check_now(e);
        nops(PWR - 1, 2'b11, "R1");
        push(C_PRE, 12'h400, 2'd0, 2'b11, 1'b0, 16'h0, 1'b0, 16'h0, "R2");
        nops(RP - 1, 2'b11, "R2");
        for (int k = 0; k < 8; k++) begin
            push(C_REF, 12'h0, 2'd0, 2'b11, 1'b0, 16'h0, 1'b0, 16'h0, "R2");
            nops(RFC - 1, 2'b11, "R2");
        end
        push(C_MRS, 12'h220, 2'd0, 2'b11, 1'b0, 16'h0, 1'b0, 16'h0, "R3");
        nops(MRD - 1, 2'b11, "R3");
        nops(1, 2'b00, "R6");
        drain();
        acc_cnt = 0;
    endtask

    task automatic idle_tick();
        req = 1'b0;
        nops(1, 2'b00, "R6");
        drain();
    endtask

    task automatic access(bit wr, logic [15:0] d, bit hold);
        string t;
        t = wr ? "R4" : "R5";
        req = 1'b1; wr_sel = wr; wdata = d;
        push(C_ACT, ROW, BANK, 2'b00, 1'b0, 16'h0, 1'b0, 16'h0, t);
        nops(RCD - 1, 2'b00, "R9");
        if (wr) begin
            push(C_WR, CADR, BANK, 2'b00, 1'b1, d, 1'b0, 16'h0, "R4");
            nops(WRP - 1, 2'b00, "R9");
        end else begin
            push(C_RD, CADR, BANK, 2'b00, 1'b0, 16'h0, 1'b0, 16'h0, "R5");
            nops(CL - 1, 2'b00, "R9");
            push(C_NOP, 12'h0, 2'd0, 2'b00, 1'b1, last_wr, 1'b0, 16'h0, "R5");
            push(C_NOP, 12'h0, 2'd0, 2'b00, 1'b0, 16'h0, 1'b1, last_wr, "R5");
        end
        acc_cnt++;
        if (acc_cnt == NACC) begin
            push(C_REF, 12'h0, 2'd0, 2'b00, 1'b0, 16'h0, 1'b0, 16'h0, "R7");
            nops(RFC - 1, 2'b00, "R7");
            acc_cnt = 0;
        end
        nops(1, 2'b00, "R6");
        @(negedge clk);
        check_now(q.pop_front());
        req = hold;
        wdata = ~d;
        wr_sel = ~wr;
        drain();
        if (wr) last_wr = d;
    endtask

    initial begin
        do_reset();
        idle_tick();
        idle_tick();
        access(1'b0, 16'h0000, 1'b0);          // read before any write
        access(1'b1, 16'h1234, 1'b0);
        idle_tick();
        access(1'b0, 16'h0000, 1'b0);
        access(1'b1, 16'hA55A, 1'b1);          // back to back with req held
        access(1'b0, 16'h0000, 1'b1);
        access(1'b1, 16'hFFFF, 1'b0);
        access(1'b0, 16'h0000, 1'b0);
        // fill up to and past two refresh intervals, 64th access held
        for (int i = 0; i < 2 * NACC + 6; i++) begin
            access((i % 3) != 0, 16'(16'h0101 * i + 16'h0F0F), (acc_cnt == NACC - 1) || (i % 5 == 0));
            if (i % 7 == 0) idle_tick();
        end
        idle_tick();
        // R10: reset in the middle of a write, right after ACTIVE
        access(1'b1, 16'h5AA5, 1'b0);
        req = 1'b1; wr_sel = 1'b1; wdata = 16'h7777;
        @(negedge clk);
        do_reset();
        idle_tick();
        access(1'b0, 16'h0000, 1'b0);          // word from before the reset
        access(1'b1, 16'h0BAD, 1'b0);
        access(1'b0, 16'h0000, 1'b0);
        idle_tick();
        summary();
    end

endmodule